// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer on a small 16-bit register bus. Software sets up an 8-bit timeout in half-second steps. It then sets an enable bit, which starts the countdown. From that point the enable bit and the timeout are frozen until the next reset. To keep the system alive, software must service the watchdog by writing a fixed pair of key words, in order, to a service register. If no valid service arrives within the programmed period, the block raises a one-cycle reset request. It then begins a fresh period on its own and stays enabled.

A prescaler divides the system clock down to one tick every half second, using the `TICK_DIV` parameter (at least 2). A timeout field value N gives a period of N+1 ticks, which is (N+1)/2 seconds. For a whole number S of seconds, software writes 2·S−1.

The control side is a two-state machine. `CFG_OPEN` accepts configuration writes. A control write with the enable bit set takes it to `CFG_LOCKED`, and nothing leaves `CFG_LOCKED` except reset. The service side is a second two-state machine:
- `KS_IDLE` moves to `KS_ARMED` on a write of 0x5555 to the service register.
- `KS_ARMED` returns to `KS_IDLE` on a write of 0xAAAA, which issues a service pulse.
- `KS_ARMED` also returns to `KS_IDLE` on a write of any other value, which aborts the sequence.
- `KS_ARMED` stays where it is on a repeated 0x5555.
- `KS_IDLE` stays where it is on any write other than 0x5555.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the control register reads 0x0000, the watchdog is disabled and `wdog_rst_o` is low.
- R2: While the enable bit is clear, a write to byte offset 0 loads the timeout from data bits 15:8 and the enable bit from data bit 2. The control register reads back as {timeout, 5'b0, enable, 2'b0}, so all other bits read 0.
- R3: Once the enable bit is set, later writes to offset 0 change neither the timeout nor the enable bit.
- R4: Reads at offset 0 return the control image. Reads at offset 2 (service) and at offsets 1 and 3 return 0x0000.
- R5: The first reset request rises in the cycle after clock edge (N+1)·TICK_DIV, counted from the edge that captured the enabling write.
- R6: Each request lasts exactly one cycle. Enable stays set, and the next request follows (N+1)·TICK_DIV edges later if no service arrives.
- R7: A service is a write of 0x5555 to offset 2 followed by a write of 0xAAAA to offset 2. Writes to other offsets may come between the two. A service restarts the full period from the edge that captured the 0xAAAA write.
- R8: A write of any value other than 0x5555 or 0xAAAA to offset 2 after 0x5555 aborts the sequence. A repeated 0x5555 keeps the sequence armed.
- R9: A write of 0xAAAA to offset 2 without a pending 0x5555 has no effect on the countdown.
- R10: A service captured on the same edge at which the period would expire wins: no request is issued and a full period starts.
- R11: While disabled, no reset request is issued, and key writes do not start a countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write when high, with bus_sel_i |
| bus_addr_i | input | 2 | Byte offset: 0 control, 2 service |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational from bus_addr_i |
| wdog_rst_o | output | 1 | One-cycle reset request |

## Verification
Read data is combinational, so the bench samples it at the falling edge in the same cycle as the address. Control writes show up in the read image one edge after they are captured. The reset request is registered: it is due in the cycle after edge (N+1)·TICK_DIV, counted from the enabling or servicing edge. The bench keeps an edge-accurate age counter for this and compares `wdog_rst_o` at every falling edge. To hit the coincident-service case, the bench waits until its model is one edge short of expiry and only then drives 0xAAAA.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 2;
    localparam int TMO_W   = 8;
    localparam int TMO_LSB = 8;
    localparam int EN_BIT  = 2;

    localparam logic [ADDR_W-1:0] OFF_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] OFF_SVC  = 2'd2;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 16'h5555;
    localparam logic [DATA_W-1:0] KEY_SECOND = 16'hAAAA;

    typedef enum logic [0:0] {
        KS_IDLE  = 1'b0,
        KS_ARMED = 1'b1
    } key_state_e;

    typedef enum logic [0:0] {
        CFG_OPEN   = 1'b0,
        CFG_LOCKED = 1'b1
    } cfg_state_e;
endpackage

// File: rtl/wdog_key_fsm.sv
module wdog_key_fsm
    import wdog_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              kick_o
);
    key_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= KS_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (wr_i) begin
            unique case (state_q)
                KS_IDLE:  state_d = (data_i == KEY_FIRST) ? KS_ARMED : KS_IDLE;
                KS_ARMED: state_d = (data_i == KEY_FIRST) ? KS_ARMED : KS_IDLE;
                default:  state_d = KS_IDLE;
            endcase
        end
    end

    always_comb begin
        kick_o = 1'b0;
        unique case (state_q)
            KS_IDLE:  kick_o = 1'b0;
            KS_ARMED: kick_o = wr_i && (data_i == KEY_SECOND);
            default:  kick_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
    import wdog_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [TMO_W-1:0]  tmo_o,
    output logic              en_o
);
    cfg_state_e       state_q, state_d;
    logic [TMO_W-1:0] tmo_q, tmo_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= CFG_OPEN;
            tmo_q   <= '0;
        end else begin
            state_q <= state_d;
            tmo_q   <= tmo_d;
        end
    end

    always_comb begin
        state_d = state_q;
        tmo_d   = tmo_q;
        unique case (state_q)
            CFG_OPEN: begin
                if (wr_i) begin
                    tmo_d = data_i[TMO_LSB +: TMO_W];
                    if (data_i[EN_BIT]) state_d = CFG_LOCKED;
                end
            end
            CFG_LOCKED: begin
                state_d = CFG_LOCKED;
            end
            default: state_d = CFG_OPEN;
        endcase
    end

    always_comb begin
        tmo_o = tmo_q;
        en_o  = (state_q == CFG_LOCKED);
    end

    a_r3_en_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_o |=> en_o);
    a_r3_tmo_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_o |=> $stable(tmo_o));
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int DIV = 100_000_000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic clr_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                    cnt_q <= '0;
        else if (!en_i || clr_i)        cnt_q <= '0;
        else if (cnt_q == LAST)         cnt_q <= '0;
        else                            cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = en_i && !clr_i && (cnt_q == LAST);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             kick_i,
    input  logic             tick_i,
    input  logic [TMO_W-1:0] tmo_i,
    output logic             expire_o
);
    logic [TMO_W-1:0] elapsed_q;
    logic             expire_q;
    logic             at_limit;

    assign at_limit = (elapsed_q == tmo_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            elapsed_q <= '0;
        end else if (!en_i || kick_i) begin
            elapsed_q <= '0;
        end else if (tick_i) begin
            elapsed_q <= at_limit ? '0 : elapsed_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) expire_q <= 1'b0;
        else         expire_q <= en_i && !kick_i && tick_i && at_limit;
    end

    assign expire_o = expire_q;

    a_r5_elapsed_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i |-> (elapsed_q <= tmo_i));
    a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_o |=> !expire_o);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdog_pkg::*;
#(
    parameter int TICK_DIV = 100_000_000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_sel_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              wdog_rst_o
);
    logic             wr_ctrl, wr_svc;
    logic [TMO_W-1:0] tmo;
    logic             en;
    logic             kick;
    logic             tick;

    assign wr_ctrl = bus_sel_i && bus_we_i && (bus_addr_i == OFF_CTRL);
    assign wr_svc  = bus_sel_i && bus_we_i && (bus_addr_i == OFF_SVC);

    wdog_ctrl_reg u_ctrl (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_i   (wr_ctrl),
        .data_i (bus_wdata_i),
        .tmo_o  (tmo),
        .en_o   (en)
    );

    wdog_key_fsm u_keys (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_i   (wr_svc),
        .data_i (bus_wdata_i),
        .kick_o (kick)
    );

    wdog_prescaler #(.DIV(TICK_DIV)) u_presc (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en),
        .clr_i  (kick),
        .tick_o (tick)
    );

    wdog_counter u_cnt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .en_i     (en),
        .kick_i   (kick),
        .tick_i   (tick),
        .tmo_i    (tmo),
        .expire_o (wdog_rst_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == OFF_CTRL) begin
            bus_rdata_o[TMO_LSB +: TMO_W] = tmo;
            bus_rdata_o[EN_BIT]           = en;
        end
    end

    a_r11_no_pulse_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wdog_rst_o |-> en);
    a_r10_service_blocks_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (kick && en) |=> !wdog_rst_o);
endmodule

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;
    localparam int P = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, we = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wd = 16'h0;
    logic [15:0] rdata;
    logic        wrst;

    int n_chk = 0, n_bad = 0, cyc = 0;
    string cur_req = "R1";

    logic [7:0] m_tmo = 8'h0;
    logic       m_en = 1'b0, m_ks = 1'b0, m_exp = 1'b0;
    int         m_age = 0;

    always #2.5 clk = ~clk;

    keyed_watchdog #(.TICK_DIV(P)) u_keyed_watchdog (
        .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wd), .bus_rdata_o(rdata), .wdog_rst_o(wrst)
    );

    function automatic logic [15:0] ctrl_image(logic [7:0] t, logic e);
        return {t, 5'b0, e, 2'b0};
    endfunction

    function automatic logic [15:0] exp_read(logic [1:0] a);
        return (a == 2'd0) ? ctrl_image(m_tmo, m_en) : 16'h0;
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic model_edge();
        logic wc, ws, kk;
        wc = sel && we && addr == 2'd0;
        ws = sel && we && addr == 2'd2;
        kk = ws && m_ks && wd == 16'hAAAA;
        if (ws) m_ks = (wd == 16'h5555);
        if (m_en) begin
            if (kk) begin
                m_age = 0; m_exp = 1'b0;
            end else begin
                m_age++;
                if (m_age == (int'(m_tmo) + 1) * P) begin
                    m_exp = 1'b1; m_age = 0;
                end else m_exp = 1'b0;
            end
        end else begin
            m_exp = 1'b0; m_age = 0;
            if (wc) begin
                m_tmo = wd[15:8]; m_en = wd[2];
            end
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cyc++;
        chk(cur_req, {15'b0, wrst}, {15'b0, m_exp});
        chk(cur_req, rdata, exp_read(addr));
    endtask

    task automatic drive(logic s, logic w, logic [1:0] a, logic [15:0] d);
        sel = s; we = w; addr = a; wd = d;
        step();
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1", rdata, 16'h0000);
        chk("R1", {15'b0, wrst}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", rdata, 16'h0000);

        cur_req = "R2";
        drive(1, 1, 2'd0, 16'h03FB);
        chk("R2", rdata, 16'h0300);
        drive(1, 1, 2'd0, 16'h0100);
        chk("R2", rdata, 16'h0100);

        cur_req = "R4";
        addr = 2'd2; #1; chk("R4", rdata, 16'h0);
        addr = 2'd1; #1; chk("R4", rdata, 16'h0);
        addr = 2'd3; #1; chk("R4", rdata, 16'h0);
        addr = 2'd0;

        cur_req = "R11";
        drive(1, 1, 2'd2, 16'h5555);
        drive(1, 1, 2'd2, 16'hAAAA);
        idle(40);

        for (int i = 0; i < 200; i++) begin
            logic [15:0] r;
            r = 16'($urandom());
            case ($urandom_range(0, 3))
                0: drive(1, 1, 2'd0, r & 16'hFFFB);
                1: drive(1, 1, 2'd2, ($urandom_range(0, 1) != 0) ? 16'h5555 : 16'hAAAA);
                2: drive(0, 0, 2'($urandom_range(0, 3)), 16'h0);
                default: drive(1, 1, 2'($urandom_range(0, 3)) | 2'd1, r);
            endcase
        end

        cur_req = "R5";
        drive(1, 1, 2'd0, 16'h0204);
        chk("R5", rdata, 16'h0204);
        cur_req = "R3";
        drive(1, 1, 2'd0, 16'hFF00);
        chk("R3", rdata, 16'h0204);
        cur_req = "R5";
        idle(10);
        cur_req = "R6";
        idle(40);

        cur_req = "R7";
        drive(1, 1, 2'd2, 16'h5555);
        drive(1, 1, 2'd0, 16'h1234);
        drive(1, 1, 2'd2, 16'hAAAA);
        chk("R7", 16'(m_age), 16'd0);
        idle(14);

        cur_req = "R8";
        drive(1, 1, 2'd2, 16'h5555);
        drive(1, 1, 2'd2, 16'h0F0F);
        drive(1, 1, 2'd2, 16'hAAAA);
        drive(1, 1, 2'd2, 16'h5555);
        drive(1, 1, 2'd2, 16'h5555);
        drive(1, 1, 2'd2, 16'hAAAA);
        idle(14);

        cur_req = "R9";
        drive(1, 1, 2'd2, 16'hAAAA);
        drive(1, 1, 2'd2, 16'hAAAA);
        idle(14);

        cur_req = "R10";
        drive(1, 1, 2'd2, 16'h5555);
        while (m_age != 11) step();
        drive(1, 1, 2'd2, 16'hAAAA);
        chk("R10", {15'b0, wrst}, 16'h0);
        idle(14);

        cur_req = "R6";
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] r;
            r = 16'($urandom());
            case ($urandom_range(0, 5))
                0: drive(1, 1, 2'd2, 16'h5555);
                1: drive(1, 1, 2'd2, 16'hAAAA);
                2: drive(1, 1, 2'd2, r);
                3: drive(1, 1, 2'($urandom_range(0, 3)), r);
                default: drive(0, 0, 2'($urandom_range(0, 3)), 16'h0);
            endcase
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule